// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running time-of-day count in nanoseconds for a precision time protocol (IEEE 1588) subsystem. Every enabled clock cycle the count advances by a programmable nominal step. A second, independent step value can replace the nominal one on one cycle out of every N. Choosing that step slightly above or below the nominal step trims the counter's effective rate, so a software servo can steer frequency without touching the reference clock.

Software reaches the block through a simple word-addressed write port and a combinational read port. It can load a new time directly, restart the count from zero, or take a snapshot of the live count and read it back later. An optional period register folds the count back toward zero when it reaches a programmed value. The live count is driven out continuously so that compare channels elsewhere on the chip can watch it.

Top module: `ptc_time_counter`

## Requirements
- R1: After reset the live count, the snapshot and every register read back as zero, and the counter is stopped.
- R2: While the enable bit (CTRL bit 0) is clear, the live count does not change unless software loads or restarts it.
- R3: While enabled, the count grows on each clock by the nominal step held in INC bits [6:0] (address 2), when no correction applies.
- R4: Writing K to CORR (address 3) makes every (K+1)-th advancing cycle add the correction step from INC bits [14:8] in place of the nominal step. The first such cycle is the (K+1)-th advancing cycle after reset, a restart or a CORR write.
- R5: When K is zero or the correction step is zero, every advancing cycle adds the nominal step.
- R6: With the fold bit (CTRL bit 4) set, a cycle whose sum reaches or passes PERIOD (address 4) stores the sum minus PERIOD, which is exactly zero when the sum equals PERIOD. With the bit clear, the count wraps at 2^CNT_W.
- R7: Writing CTRL with bit 11 set copies the live count of that cycle into the snapshot. A read of TIME (address 1) in that same cycle returns the previous snapshot; from the next cycle on it returns the new one.
- R8: A write to TIME loads the live count with the written value on the next cycle, and advancing resumes from there. The load cycle does not advance the correction phase.
- R9: Writing CTRL with bit 9 set clears the live count to zero on the next cycle and restarts the correction phase.
- R10: CTRL reads back only bits 0 and 4 as last written. Bits 9 and 11 always read as zero.
- R11: INC, CORR and PERIOD read back as written, masked to their field widths. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | DATA_W | Combinational read data |
| time_o | output | CNT_W | Live count for compare channels |

## Verification
The bench builds the block with a 12-bit count, 16-bit data and a 4-bit correction interval. With a count that narrow, both the natural wrap at 4096 and the folding at a small PERIOD occur within a few dozen cycles. The 4-bit interval lets the bench sweep every value of K from 0 to 4 against several nominal and correction steps, so each correction slot and the disabled cases are covered. A cycle-by-cycle arithmetic model in the bench predicts the live count on every cycle. Captures, restarts and loads are placed mid-run, so that the priority and timing of those pulses are checked against that model.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_TIME   = 3'd1;
   localparam logic [ADDR_W-1:0] A_INC    = 3'd2;
   localparam logic [ADDR_W-1:0] A_CORR   = 3'd3;
   localparam logic [ADDR_W-1:0] A_PERIOD = 3'd4;

   localparam int B_EN      = 0;
   localparam int B_FOLD    = 4;
   localparam int B_RESTART = 9;
   localparam int B_CAPTURE = 11;

   localparam int CORR_LSB  = 8;

   typedef struct packed {
      logic fold;
      logic en;
   } ptc_ctrl_t;
endpackage

// File: rtl/ptc_regs.sv
module ptc_regs
   import ptc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int STEP_W = 7,
   parameter int CORR_W = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic [CNT_W-1:0]    snap_i,
   output logic [DATA_W-1:0]   rd_data,
   output ptc_ctrl_t           ctrl_o,
   output logic [STEP_W-1:0]   nom_step_o,
   output logic [STEP_W-1:0]   corr_step_o,
   output logic [CORR_W-1:0]   corr_int_o,
   output logic [CNT_W-1:0]    period_o,
   output logic                load_o,
   output logic [CNT_W-1:0]    load_val_o,
   output logic                restart_o,
   output logic                capture_o,
   output logic                corr_wr_o
);
   localparam int INC_TOP = CORR_LSB + STEP_W;

   generate
      if (STEP_W < 1 || STEP_W > CORR_LSB) begin : g_bad_step
         $error("ptc_regs: STEP_W must lie in 1..%0d", CORR_LSB);
      end
      if (DATA_W < INC_TOP || DATA_W < B_CAPTURE + 1) begin : g_bad_data
         $error("ptc_regs: DATA_W too narrow for the increment fields");
      end
      if (DATA_W < CNT_W || DATA_W < CORR_W) begin : g_bad_cnt
         $error("ptc_regs: DATA_W must cover CNT_W and CORR_W");
      end
   endgenerate

   ptc_ctrl_t          ctrl_q;
   logic [STEP_W-1:0]  nom_q, cs_q;
   logic [CORR_W-1:0]  k_q;
   logic [CNT_W-1:0]   per_q;

   logic wr_ctrl, wr_inc, wr_corr, wr_per;
   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_inc  = wr_en && (wr_addr == A_INC);
   assign wr_corr = wr_en && (wr_addr == A_CORR);
   assign wr_per  = wr_en && (wr_addr == A_PERIOD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         nom_q  <= '0;
         cs_q   <= '0;
         k_q    <= '0;
         per_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.en   <= wr_data[B_EN];
            ctrl_q.fold <= wr_data[B_FOLD];
         end
         if (wr_inc) begin
            nom_q <= wr_data[STEP_W-1:0];
            cs_q  <= wr_data[CORR_LSB +: STEP_W];
         end
         if (wr_corr) k_q   <= wr_data[CORR_W-1:0];
         if (wr_per)  per_q <= wr_data[CNT_W-1:0];
      end
   end

   assign ctrl_o      = ctrl_q;
   assign nom_step_o  = nom_q;
   assign corr_step_o = cs_q;
   assign corr_int_o  = k_q;
   assign period_o    = per_q;
   assign load_o      = wr_en && (wr_addr == A_TIME);
   assign load_val_o  = wr_data[CNT_W-1:0];
   assign restart_o   = wr_ctrl && wr_data[B_RESTART];
   assign capture_o   = wr_ctrl && wr_data[B_CAPTURE];
   assign corr_wr_o   = wr_corr;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL: begin
            rd_data[B_EN]   = ctrl_q.en;
            rd_data[B_FOLD] = ctrl_q.fold;
         end
         A_TIME:   rd_data[CNT_W-1:0] = snap_i;
         A_INC: begin
            rd_data[STEP_W-1:0]         = nom_q;
            rd_data[CORR_LSB +: STEP_W] = cs_q;
         end
         A_CORR:   rd_data[CORR_W-1:0] = k_q;
         A_PERIOD: rd_data[CNT_W-1:0]  = per_q;
         default:  rd_data = '0;
      endcase
   end

   // R10: pulse bits never visible on readback
   p_pulse_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_CTRL) |-> (!rd_data[B_RESTART] && !rd_data[B_CAPTURE]));

   // R11: a register write is visible on the next cycle
   p_period_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_per |=> (per_q == $past(wr_data[CNT_W-1:0])));
endmodule

// File: rtl/ptc_step_sel.sv
module ptc_step_sel #(
   parameter int STEP_W = 7,
   parameter int CORR_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance_i,
   input  logic              clear_i,
   input  logic [STEP_W-1:0] nom_step_i,
   input  logic [STEP_W-1:0] corr_step_i,
   input  logic [CORR_W-1:0] corr_int_i,
   output logic [STEP_W-1:0] step_o,
   output logic              use_corr_o
);
   generate
      if (CORR_W < 1) begin : g_bad_corr
         $error("ptc_step_sel: CORR_W must be at least 1");
      end
   endgenerate

   logic [CORR_W-1:0] phase_q;
   logic              active;

   assign active     = (corr_int_i != '0) && (corr_step_i != '0);
   assign use_corr_o = active && (phase_q == corr_int_i);
   assign step_o     = use_corr_o ? corr_step_i : nom_step_i;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         phase_q <= '0;
      end else if (advance_i) begin
         if (use_corr_o || !active) phase_q <= '0;
         else                       phase_q <= phase_q + 1'b1;
      end
   end

   // R5: correction only when interval and step are both nonzero
   p_corr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      use_corr_o |-> ((corr_int_i != '0) && (corr_step_i != '0)));

   // R4: phase never overruns the programmed interval
   p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= corr_int_i);

   // R4: two corrected cycles are never adjacent
   p_corr_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (use_corr_o && advance_i) |=> !use_corr_o);
endmodule

// File: rtl/ptc_accum.sv
module ptc_accum #(
   parameter int CNT_W    = 32,
   parameter int STEP_W   = 7,
   parameter bit HAS_FOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              fold_i,
   input  logic [CNT_W-1:0]  period_i,
   input  logic              load_i,
   input  logic [CNT_W-1:0]  load_val_i,
   input  logic              restart_i,
   input  logic              capture_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  snap_o
);
   localparam int SUM_W = CNT_W + 1;

   generate
      if (CNT_W <= STEP_W) begin : g_bad_cnt
         $error("ptc_accum: CNT_W must exceed STEP_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, snap_q, adv_w;
   logic [SUM_W-1:0] sum_w;

   assign sum_w = {1'b0, cnt_q} + SUM_W'(step_i);

   generate
      if (HAS_FOLD) begin : g_fold
         logic [SUM_W-1:0] per_x;
         logic [SUM_W-1:0] diff_w;
         assign per_x  = {1'b0, period_i};
         assign diff_w = sum_w - per_x;
         always_comb begin
            if (fold_i && (sum_w >= per_x)) adv_w = diff_w[CNT_W-1:0];
            else                            adv_w = sum_w[CNT_W-1:0];
         end

         // R6: a folded count stays below the period
         p_fold_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i && fold_i && !load_i && !restart_i &&
             (cnt_q < period_i) && (CNT_W'(step_i) <= period_i))
            |=> (cnt_q < $past(period_i)));
      end else begin : g_plain
         assign adv_w = sum_w[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i) cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (en_i)           cnt_q <= adv_w;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         snap_q <= '0;
      else if (capture_i) snap_q <= cnt_q;
   end

   assign count_o = cnt_q;
   assign snap_o  = snap_q;

   p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

   p_load_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !restart_i) |=> (cnt_q == $past(load_val_i)));

   p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !load_i && !restart_i) |=> $stable(cnt_q));

   p_snapshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> (snap_q == $past(cnt_q)));
endmodule

// File: rtl/ptc_time_counter.sv
module ptc_time_counter
   import ptc_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 32,
   parameter int STEP_W   = 7,
   parameter int CORR_W   = 31,
   parameter bit HAS_FOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  time_o
);
   ptc_ctrl_t          ctrl;
   logic [STEP_W-1:0]  nom_step, corr_step, step;
   logic [CORR_W-1:0]  corr_int;
   logic [CNT_W-1:0]   period, load_val, snap;
   logic               load, restart, capture, corr_wr, use_corr;
   logic               advance, phase_clr;

   assign advance   = ctrl.en && !load && !restart;
   assign phase_clr = restart || corr_wr;

   ptc_regs #(
      .DATA_W (DATA_W), .CNT_W (CNT_W), .STEP_W (STEP_W), .CORR_W (CORR_W)
   ) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (rd_addr),
      .snap_i      (snap),
      .rd_data     (rd_data),
      .ctrl_o      (ctrl),
      .nom_step_o  (nom_step),
      .corr_step_o (corr_step),
      .corr_int_o  (corr_int),
      .period_o    (period),
      .load_o      (load),
      .load_val_o  (load_val),
      .restart_o   (restart),
      .capture_o   (capture),
      .corr_wr_o   (corr_wr)
   );

   ptc_step_sel #(
      .STEP_W (STEP_W), .CORR_W (CORR_W)
   ) step_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .advance_i   (advance),
      .clear_i     (phase_clr),
      .nom_step_i  (nom_step),
      .corr_step_i (corr_step),
      .corr_int_i  (corr_int),
      .step_o      (step),
      .use_corr_o  (use_corr)
   );

   ptc_accum #(
      .CNT_W (CNT_W), .STEP_W (STEP_W), .HAS_FOLD (HAS_FOLD)
   ) accum_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (ctrl.en),
      .fold_i     (ctrl.fold),
      .period_i   (period),
      .load_i     (load),
      .load_val_i (load_val),
      .restart_i  (restart),
      .capture_i  (capture),
      .step_i     (step),
      .count_o    (time_o),
      .snap_o     (snap)
   );

   // R3: an uncorrected advancing cycle adds the nominal step (no fold)
   p_nominal_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !use_corr && !ctrl.fold) |=>
      (time_o == $past(time_o) + CNT_W'($past(nom_step))));
endmodule

// File: tb/ptc_time_counter_tb_top.sv
module ptc_time_counter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 12;
   localparam int DW = 16;
   localparam int SW = 7;
   localparam int KW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] time_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptc_time_counter #(
      .DATA_W (DW), .CNT_W (CW), .STEP_W (SW), .CORR_W (KW), .HAS_FOLD (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data), .time_o (time_o)
   );

   // Arithmetic reference model, updated at the same edges as the design
   logic          m_en, m_fold;
   logic [SW-1:0] m_nom, m_cs;
   logic [KW-1:0] m_k, m_ph;
   logic [CW-1:0] m_per, m_cnt, m_snap;
   logic          t_act, t_use, t_ctrl, t_rst, t_load, t_corr;
   logic [CW:0]   t_sum;
   logic [SW-1:0] t_step;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en <= 0; m_fold <= 0; m_nom <= 0; m_cs <= 0; m_k <= 0; m_ph <= 0;
         m_per <= 0; m_cnt <= 0; m_snap <= 0;
      end else begin
         t_ctrl = wr_en && (wr_addr == 3'd0);
         t_rst  = t_ctrl && wr_data[9];
         t_load = wr_en && (wr_addr == 3'd1);
         t_corr = wr_en && (wr_addr == 3'd3);
         t_act  = (m_k != 0) && (m_cs != 0);
         t_use  = t_act && (m_ph == m_k);
         t_step = t_use ? m_cs : m_nom;
         t_sum  = {1'b0, m_cnt} + (CW+1)'(t_step);
         if (m_fold && (t_sum >= {1'b0, m_per})) t_sum = t_sum - {1'b0, m_per};
         if (t_ctrl && wr_data[11]) m_snap <= m_cnt;
         if (t_rst)       m_cnt <= 0;
         else if (t_load) m_cnt <= wr_data[CW-1:0];
         else if (m_en)   m_cnt <= t_sum[CW-1:0];
         if (t_rst || t_corr)          m_ph <= 0;
         else if (m_en && !t_load)     m_ph <= (t_use || !t_act) ? '0 : m_ph + 1'b1;
         if (t_ctrl) begin m_en <= wr_data[0]; m_fold <= wr_data[4]; end
         if (wr_en && wr_addr == 3'd2) begin m_nom <= wr_data[6:0]; m_cs <= wr_data[14:8]; end
         if (t_corr) m_k <= wr_data[KW-1:0];
         if (wr_en && wr_addr == 3'd4) m_per <= wr_data[CW-1:0];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input string req);
      @(posedge clk);
      @(negedge clk);
      chk(req, 32'(time_o), 32'(m_cnt));
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input string req);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(req);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string req);
      rd_addr = a;
      #1;
      chk(req, 32'(rd_data), 32'(exp));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [CW-1:0] cap_exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", 32'(time_o), 0);
      for (int a = 0; a < 8; a++) rd(3'(a), '0, "R1");

      // R3 nominal stepping, then R2 hold
      wr(3'd2, 16'h0003, "R3");
      wr(3'd0, 16'h0001, "R3");
      for (int i = 0; i < 10; i++) tick("R3");
      chk("R3", 32'(time_o), 30);
      wr(3'd0, 16'h0000, "R2");
      for (int i = 0; i < 5; i++) tick("R2");
      chk("R2", 32'(time_o), 33);

      // R4 / R5 sweep of interval, correction step and nominal step
      for (int n = 0; n < 3; n++) begin
         for (int k = 0; k < 5; k++) begin
            for (int c = 0; c < 3; c++) begin
               logic [6:0] nomv, csv;
               string tag;
               nomv = (n == 0) ? 7'd1 : (n == 1) ? 7'd2 : 7'd5;
               csv  = (c == 0) ? 7'd0 : (c == 1) ? 7'd4 : 7'd9;
               tag  = (k != 0 && csv != 0) ? "R4" : "R5";
               wr(3'd2, {1'b0, csv, 1'b0, nomv}, tag);
               wr(3'd3, 16'(k), tag);
               wr(3'd1, 16'h0000, tag);
               wr(3'd0, 16'h0001, tag);
               for (int i = 0; i < 14; i++) tick(tag);
               wr(3'd0, 16'h0000, tag);
            end
         end
      end
      // explicit R4 case: K=2, nominal 1, correction 4 -> 1,1,4 pattern
      wr(3'd2, 16'h0401, "R4");
      wr(3'd3, 16'h0002, "R4");
      wr(3'd1, 16'h0000, "R4");
      wr(3'd0, 16'h0001, "R4");
      for (int i = 0; i < 6; i++) tick("R4");
      chk("R4", 32'(time_o), 12);
      wr(3'd3, 16'h0000, "R5");

      // R6 folding at a period, non-dividing and exact steps
      wr(3'd4, 16'd100, "R6");
      wr(3'd2, 16'h0007, "R6");
      wr(3'd0, 16'h0211, "R6");
      for (int i = 0; i < 40; i++) tick("R6");
      wr(3'd2, 16'h0005, "R6");
      wr(3'd0, 16'h0211, "R6");
      for (int i = 0; i < 19; i++) tick("R6");
      chk("R6", 32'(time_o), 95);
      tick("R6");
      chk("R6", 32'(time_o), 0);

      // R8 load, then R6 natural wrap with folding off
      wr(3'd0, 16'h0001, "R6");
      wr(3'd2, 16'h0003, "R8");
      wr(3'd1, 16'd4090, "R8");
      chk("R8", 32'(time_o), 4090);
      tick("R6");
      tick("R6");
      chk("R6", 32'(time_o), 0);
      for (int i = 0; i < 4; i++) tick("R6");

      // R7 capture timing, twice
      for (int j = 0; j < 2; j++) begin
         wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0801;
         rd_addr = 3'd1;
         #1;
         chk("R7", 32'(rd_data), 32'(m_snap));
         cap_exp = m_cnt;
         tick("R7");
         wr_en = 1'b0;
         rd(3'd1, 16'(cap_exp), "R7");
         for (int i = 0; i < 3; i++) tick("R7");
      end

      // R9 restart
      wr(3'd0, 16'h0201, "R9");
      chk("R9", 32'(time_o), 0);
      tick("R9");
      chk("R9", 32'(time_o), 3);

      // R10 control readback
      wr(3'd0, 16'hFFFF, "R10");
      rd(3'd0, 16'h0011, "R10");
      wr(3'd0, 16'h0000, "R10");
      rd(3'd0, 16'h0000, "R10");

      // R11 register readback
      wr(3'd2, 16'hFFFF, "R11");
      rd(3'd2, 16'h7F7F, "R11");
      wr(3'd3, 16'hFFFF, "R11");
      rd(3'd3, 16'h000F, "R11");
      wr(3'd4, 16'hFFFF, "R11");
      rd(3'd4, 16'h0FFF, "R11");
      rd(3'd6, 16'h0000, "R11");

      finish_run();
   end
endmodule